// File: doc/BRIEF.md
# External Interrupt Conditioner with Priority Control Register

This block takes one active-low external interrupt pin, brings it into the system clock domain through a short flop chain, and turns it into an interrupt request. The request can be level-sensitive, following the synchronized pin, or falling-edge triggered. In edge mode a capture latch records each high-to-low transition and holds it until a service acknowledge clears it.

The same block holds one 32-bit control/status register. The register carries a trigger-mode bit and four 2-bit priority codes: one for the external pin, one for each of two DMA channels, and one for the host-port interrupt group. Each code is decoded into an enable and a 2-bit priority level for use by a downstream arbiter. The register also carries a read-only status bit. That bit shows the edge latch when the pin source is armed for edges. Otherwise it shows the synchronized pin, inverted so that 1 means the pin is low.

Top module: `irq_cond_prio`

## Requirements
- R1: After reset all priority codes are 00 and the trigger-mode bit is 0. With the pin held high, `reg_rdata` reads 0x00000000, `irq_req` is 0 and `src_en` is 0.
- R2: The pin passes through a two-flop synchronizer, reset to 1. A pin change applied before clock edge k shows in the status bit (level mode) after edge k+1 and not after edge k.
- R3: In level mode (bit 2 = 0) with the pin source enabled, status bit 11 and `irq_req` are 1 while the synchronized pin is low, and 0 while it is high.
- R4: In edge mode (bit 2 = 1) with the pin source enabled, a falling edge of the synchronized pin sets the latch one edge after the synchronized pin falls. Status bit 11 and `irq_req` then stay 1 after the pin returns high.
- R5: A one-cycle `irq_ack` clears the latch. If a new falling edge is detected in the same cycle as the acknowledge, the latch stays set.
- R6: When the pin source is disabled (code 00), `irq_req` is 0 and status bit 11 shows the inverted synchronized pin, even in edge mode. No edge is latched while the source is disabled.
- R7: Each 2-bit code decodes as follows: 00 means disabled with level 0, 01 means enabled at level 0, 10 means enabled at level 1, and 11 means enabled at level 2.
- R8: The register fields are: pin code at bits 1:0, trigger mode at bit 2, DMA channel 0 code at bits 17:16, DMA channel 1 code at bits 19:18, and host code at bits 21:20. Source index 0 is the pin, 1 is DMA0, 2 is DMA1 and 3 is the host port. `src_en[i]` and `src_lvl[2i+1:2i]` belong to source i.
- R9: Bits 15:12 and 31:24, and all other unassigned bits, read as 0 and ignore writes. Bit 11 cannot be written.
- R10: `irq_lvl` equals the pin source's decoded level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low external interrupt pin |
| irq_ack | input | 1 | Service acknowledge pulse for the pin request |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, including the status bit |
| irq_req | output | 1 | Conditioned pin interrupt request |
| irq_lvl | output | 2 | Priority level of the pin request |
| src_en | output | 4 | Decoded enable for each source |
| src_lvl | output | 8 | Decoded 2-bit level for each source |

## Verification
Several properties are checked on every cycle. Unassigned register bits must read zero, and a request may only appear for an enabled pin source. An armed latch must hold without an acknowledge and must set on a detected fall. A disabled code must always decode to level 0. Other behaviour is shown only by the bench's directed scenarios. These cover the exact two-edge synchronizer latency, the change in meaning of the status bit when the mode or the enable changes, the acknowledge racing a new edge, and the full decode table across all four field positions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W    = 32;
    localparam int NSRC     = 4;
    localparam int LVL_W    = 2;
    localparam int POS_MODE = 2;
    localparam int POS_STAT = 11;

    // low bit of the 2-bit code for source i (0: pin, 1..3: dma0, dma1, host)
    function automatic int code_lo(input int i);
        return (i == 0) ? 0 : 14 + 2 * i;
    endfunction

    function automatic logic [REG_W-1:0] wr_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[POS_MODE] = 1'b1;
        for (int i = 0; i < NSRC; i++) begin
            m[code_lo(i)]     = 1'b1;
            m[code_lo(i) + 1] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic             latch;
        logic             prev;
    } irqc_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_s
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_prio_decode.sv
module irqc_prio_decode #(
    parameter int LW = 2
) (
    input  logic [1:0]    code,
    output logic          en,
    output logic [LW-1:0] lvl
);
    always_comb begin
        en  = (code != 2'b00);
        lvl = en ? LW'(code - 2'd1) : '0;
    end

    always_comb begin
        a_r7_disabled_level_zero: assert (en || lvl == '0);
    end
endmodule

// File: rtl/irq_cond_prio.sv
module irq_cond_prio
    import irqc_pkg::*;
#(
    parameter int NSYNC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_pin_n,
    input  logic                  irq_ack,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  irq_req,
    output logic [LVL_W-1:0]      irq_lvl,
    output logic [NSRC-1:0]       src_en,
    output logic [NSRC*LVL_W-1:0] src_lvl
);
    localparam logic [REG_W-1:0] WMASK = wr_mask();

    irqc_state_t st_d, st_q;
    logic        pin_s, fall, armed, edge_mode, status;

    irqc_sync #(.STAGES(NSYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (irq_pin_n),
        .pin_s  (pin_s)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_dec
        irqc_prio_decode #(.LW(LVL_W)) u_dec (
            .code (st_q.ctrl[code_lo(g) +: 2]),
            .en   (src_en[g]),
            .lvl  (src_lvl[g*LVL_W +: LVL_W])
        );
    end

    always_comb begin
        edge_mode = st_q.ctrl[POS_MODE];
        armed     = edge_mode & src_en[0];
        fall      = st_q.prev & ~pin_s;
        status    = armed ? st_q.latch : ~pin_s;

        st_d      = st_q;
        st_d.prev = pin_s;
        if (reg_wr) st_d.ctrl = reg_wdata & WMASK;
        if (!armed)       st_d.latch = 1'b0;
        else if (fall)    st_d.latch = 1'b1;
        else if (irq_ack) st_d.latch = 1'b0;

        reg_rdata           = st_q.ctrl;
        reg_rdata[POS_STAT] = status;
        irq_req             = src_en[0] & status;
        irq_lvl             = src_lvl[LVL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.latch <= 1'b0;
            st_q.prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~(WMASK | (REG_W'(1) << POS_STAT))) == '0);

    a_r6_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> src_en[0]);

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_q.latch && !irq_ack && !reg_wr) |=> st_q.latch);

    a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fall && !reg_wr) |=> st_q.latch);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && irq_ack && !fall) |=> !st_q.latch);
endmodule

// File: tb/irq_cond_prio_bench.sv
module irq_cond_prio_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pin_n = 1'b1;
    logic        irq_ack = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [1:0]  irq_lvl;
    logic [3:0]  src_en;
    logic [7:0]  src_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_cond_prio u_irq_cond_prio (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .irq_ack(irq_ack),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .src_en(src_en), .src_lvl(src_lvl)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            report();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    function automatic logic [1:0] lvl_of(input logic [1:0] c);
        return (c == 2'b00) ? 2'd0 : c - 2'd1;
    endfunction

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 req", {31'b0, irq_req}, 32'h0);
        chk("R1 src_en", {28'b0, src_en}, 32'h0);
    endtask

    task automatic t_level();
        wr(32'h0000_0002); // level mode, pin code 10
        irq_pin_n = 1'b0;
        tick(1);
        chk("R2 not yet after one edge", {31'b0, reg_rdata[11]}, 32'h0);
        tick(1);
        chk("R2 R3 status low pin", {31'b0, reg_rdata[11]}, 32'h1);
        chk("R3 req", {31'b0, irq_req}, 32'h1);
        chk("R10 lvl", {30'b0, irq_lvl}, 32'h1);
        irq_pin_n = 1'b1;
        tick(2);
        chk("R3 pin high", {30'b0, irq_req, reg_rdata[11]}, 32'h0);
    endtask

    task automatic t_edge();
        wr(32'h0000_0007); // edge mode, pin code 11
        irq_pin_n = 1'b0;
        tick(2);
        chk("R4 latch not yet", {31'b0, reg_rdata[11]}, 32'h0);
        tick(1);
        chk("R4 latched", {30'b0, irq_req, reg_rdata[11]}, 32'h3);
        chk("R10 lvl edge", {30'b0, irq_lvl}, 32'h2);
        irq_pin_n = 1'b1;
        tick(3);
        chk("R4 holds after pin high", {30'b0, irq_req, reg_rdata[11]}, 32'h3);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R5 ack clears", {30'b0, irq_req, reg_rdata[11]}, 32'h0);
    endtask

    task automatic t_ack_race();
        irq_pin_n = 1'b0;
        tick(3);
        irq_pin_n = 1'b1;
        tick(3);
        chk("R5 prelatched", {31'b0, reg_rdata[11]}, 32'h1);
        irq_pin_n = 1'b0;
        tick(2);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R5 edge wins over ack", {31'b0, reg_rdata[11]}, 32'h1);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R5 plain ack clears", {31'b0, reg_rdata[11]}, 32'h0);
        irq_pin_n = 1'b1;
        tick(3);
    endtask

    task automatic t_disabled();
        wr(32'h0000_0004); // edge mode, pin code 00
        irq_pin_n = 1'b0;
        tick(3);
        chk("R6 status shows pin", {31'b0, reg_rdata[11]}, 32'h1);
        chk("R6 no req", {31'b0, irq_req}, 32'h0);
        wr(32'h0000_0005); // enable, pin still low, no new edge
        chk("R6 nothing latched", {30'b0, irq_req, reg_rdata[11]}, 32'h0);
        irq_pin_n = 1'b1;
        tick(3);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 4; c++) begin
            logic [1:0] cd[4];
            logic [31:0] w;
            logic [3:0] een;
            logic [7:0] elv;
            for (int i = 0; i < 4; i++) cd[i] = 2'((c + i) % 4);
            w = {10'b0, cd[3], cd[2], cd[1], 14'b0, cd[0]};
            wr(w);
            for (int i = 0; i < 4; i++) begin
                een[i] = (cd[i] != 2'b00);
                elv[2*i +: 2] = lvl_of(cd[i]);
            end
            chk("R7 R8 src_en", {28'b0, src_en}, {28'b0, een});
            chk("R7 R8 src_lvl", {24'b0, src_lvl}, {24'b0, elv});
            chk("R8 readback", reg_rdata, w);
            chk("R10 irq_lvl", {30'b0, irq_lvl}, {30'b0, elv[1:0]});
        end
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FFFF);
        chk("R9 only fields kept", reg_rdata, 32'h003F_0007);
        wr(32'h0000_0800);
        chk("R9 bit 11 not writable", reg_rdata, 32'h0);
        wr(32'hFF00_F000);
        chk("R9 reserved ignored", reg_rdata, 32'h0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_level();
        t_edge();
        t_ack_race();
        t_disabled();
        t_decode();
        t_reserved();
        done = 1;
        report();
    end
endmodule